// File: doc/BRIEF.md
# Word-Granular Ownership Coherence State Tracker

This block holds the coherence state of every 32-bit word in a small first-level cache that keeps coherence per word rather than per line. Each word carries a 2-bit state: Invalid, Valid, Registered (the local cache owns the word), or ReadOnly. ReadOnly uses the spare fourth code of the three-state protocol. Next to the word states the block keeps the matching shared-cache line metadata: a line valid bit, a line dirty bit and one bit per word that records that some first-level cache owns the word.

One request arrives per cycle on a single request port. The operations are load, store, acquire, fill, ownership grant and ownership revoke. Loads and stores get a registered hit/miss response one cycle later, carrying the word's prior state and data. A store to a word the cache does not own raises a registration request. A later grant makes the word Registered. An acquire drops every plain Valid word in one cycle and keeps owned and read-only words. Because owned words stay owned, a release needs no bulk writeback, and synchronization variables held as Registered hit locally. A revoke hands the owned word's data back and invalidates it.

Top module: `coh_word_tracker`

## Requirements
- R1: After reset every word state is Invalid (00), all shared-cache line metadata is clear, and rsp_valid, regq_valid and rvk_valid are low.
- R2: A load (req_op 0) gives rsp_valid one cycle later. rsp_hit is 1 exactly when the word's state is not Invalid, and a Registered word counts as a hit. rsp_state carries the state before the request, coded 00 Invalid, 01 Valid, 10 Registered, 11 ReadOnly. rsp_data carries the word's data on a hit.
- R3: An acquire (req_op 2) turns every Valid word into Invalid in a single cycle. Registered, ReadOnly and Invalid words keep their state.
- R4: A store (req_op 1) always writes its data into the word. If the word was not Registered, the response is a miss and regq_valid pulses one cycle later with the word's line and word index. If the word was Registered, the response is a hit and no registration request is raised.
- R5: A grant (req_op 4) moves the addressed word to Registered and sets that word's owned bit in the shared-cache metadata.
- R6: A fill (req_op 3) writes data and sets the state to ReadOnly when req_ro is 1 and to Valid when req_ro is 0. A fill to a Registered word changes neither its state nor its data.
- R7: A revoke (req_op 5) of a Registered word pulses rvk_valid one cycle later with the word's data. It sets the word Invalid, clears its owned bit and sets the line dirty bit. A revoke of a word that is not Registered gives no rvk_valid and changes nothing.
- R8: A fill sets the valid bit of the addressed line in the shared-cache metadata. Lines that have not been filled stay invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 3 | 0 load, 1 store, 2 acquire, 3 fill, 4 grant, 5 revoke |
| req_line | input | 2 | Line index |
| req_word | input | 2 | Word index within the line |
| req_ro | input | 1 | Access targets a read-only region |
| req_wdata | input | 32 | Store or fill data |
| rsp_valid | output | 1 | Load/store response strobe |
| rsp_hit | output | 1 | Response hit flag |
| rsp_state | output | 2 | Word state before the request |
| rsp_data | output | 32 | Word data |
| regq_valid | output | 1 | Registration request strobe |
| regq_line | output | 2 | Line of the registration request |
| regq_word | output | 2 | Word of the registration request |
| rvk_valid | output | 1 | Revoked data strobe |
| rvk_data | output | 32 | Revoked word data |
| meta_line | input | 2 | Line selected for metadata readout |
| meta_valid | output | 1 | Selected line valid bit |
| meta_dirty | output | 1 | Selected line dirty bit |
| meta_owned | output | 4 | Selected line per-word owned bits |

## Verification
Loads are run against words in each of the four states. This separates a miss on Invalid from hits on Valid, Registered and ReadOnly, and it shows that the reported state code matches the word's history. The same words are then loaded again after an acquire, which tells apart the state that must drop (Valid) from the two that must survive. Stores and revokes are each sent to owned and unowned words, which separates the request-raising path from the silent one. A fill aimed at an owned word shows that newer owned data is not overwritten. The shared-cache metadata is read back after grants, fills and revokes.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [1:0] {
    WS_INV = 2'b00,
    WS_VAL = 2'b01,
    WS_REG = 2'b10,
    WS_RO  = 2'b11
  } wstate_e;

  typedef enum logic [2:0] {
    OP_LOAD   = 3'd0,
    OP_STORE  = 3'd1,
    OP_ACQ    = 3'd2,
    OP_FILL   = 3'd3,
    OP_GRANT  = 3'd4,
    OP_REVOKE = 3'd5
  } op_e;
endpackage

// File: rtl/cwt_word_cell.sv
module cwt_word_cell
  import coh_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          sel,
  input  op_e           op,
  input  logic          ro,
  input  logic [DW-1:0] wdata,
  output wstate_e       st,
  output logic [DW-1:0] data
);
  wstate_e       st_q, st_d;
  logic          data_we;
  logic [DW-1:0] data_q;

  always_comb begin
    st_d    = st_q;
    data_we = 1'b0;
    if (en) begin
      case (op)
        OP_ACQ:    if (st_q == WS_VAL) st_d = WS_INV;
        OP_STORE:  if (sel) data_we = 1'b1;
        OP_FILL:   if (sel && st_q != WS_REG) begin
                     st_d    = ro ? WS_RO : WS_VAL;
                     data_we = 1'b1;
                   end
        OP_GRANT:  if (sel) st_d = WS_REG;
        OP_REVOKE: if (sel && st_q == WS_REG) st_d = WS_INV;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= WS_INV;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk) begin
    if (data_we) data_q <= wdata;
  end

  assign st   = st_q;
  assign data = data_q;
endmodule

// File: rtl/cwt_llc_meta.sv
module cwt_llc_meta #(
  parameter int LINES = 4,
  parameter int WORDS = 4,
  localparam int LW = $clog2(LINES),
  localparam int WW = $clog2(WORDS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   fill_en,
  input  logic                   grant_en,
  input  logic                   revoke_en,
  input  logic [LW-1:0]          line,
  input  logic [WW-1:0]          word,
  input  logic [LW-1:0]          q_line,
  output logic                   q_valid,
  output logic                   q_dirty,
  output logic [WORDS-1:0]       q_owned,
  output logic [LINES*WORDS-1:0] owned_flat
);
  logic             vld_a [LINES];
  logic             drt_a [LINES];
  logic [WORDS-1:0] own_a [LINES];

  for (genvar l = 0; l < LINES; l++) begin : g_line
    logic             v_q, v_d, d_q, d_d, hit;
    logic [WORDS-1:0] o_q, o_d;

    assign hit = (line == LW'(l));

    always_comb begin
      v_d = v_q | (fill_en & hit);
      d_d = d_q | (revoke_en & hit);
      o_d = o_q;
      if (grant_en && hit)  o_d[word] = 1'b1;
      if (revoke_en && hit) o_d[word] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        d_q <= 1'b0;
        o_q <= '0;
      end else begin
        v_q <= v_d;
        d_q <= d_d;
        o_q <= o_d;
      end
    end

    assign vld_a[l] = v_q;
    assign drt_a[l] = d_q;
    assign own_a[l] = o_q;
    assign owned_flat[l*WORDS +: WORDS] = o_q;
  end

  assign q_valid = vld_a[q_line];
  assign q_dirty = drt_a[q_line];
  assign q_owned = own_a[q_line];
endmodule

// File: rtl/coh_word_tracker.sv
module coh_word_tracker
  import coh_pkg::*;
#(
  parameter int LINES = 4,
  parameter int WORDS = 4,
  parameter int DW    = 32,
  localparam int LW    = $clog2(LINES),
  localparam int WW    = $clog2(WORDS),
  localparam int NCELL = LINES * WORDS,
  localparam int IW    = LW + WW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [2:0]       req_op,
  input  logic [LW-1:0]    req_line,
  input  logic [WW-1:0]    req_word,
  input  logic             req_ro,
  input  logic [DW-1:0]    req_wdata,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [1:0]       rsp_state,
  output logic [DW-1:0]    rsp_data,
  output logic             regq_valid,
  output logic [LW-1:0]    regq_line,
  output logic [WW-1:0]    regq_word,
  output logic             rvk_valid,
  output logic [DW-1:0]    rvk_data,
  input  logic [LW-1:0]    meta_line,
  output logic             meta_valid,
  output logic             meta_dirty,
  output logic [WORDS-1:0] meta_owned
);
  op_e             op;
  logic [IW-1:0]   cur_idx;
  wstate_e         cell_st   [NCELL];
  logic [DW-1:0]   cell_data [NCELL];
  logic [2*NCELL-1:0] st_flat;
  logic [NCELL-1:0]   owned_flat;

  assign op      = op_e'(req_op);
  assign cur_idx = {req_line, req_word};

  // word state cells, one per word of every line
  for (genvar i = 0; i < NCELL; i++) begin : g_cell
    cwt_word_cell #(.DW(DW)) u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (req_valid),
      .sel   (cur_idx == IW'(i)),
      .op    (op),
      .ro    (req_ro),
      .wdata (req_wdata),
      .st    (cell_st[i]),
      .data  (cell_data[i])
    );
    assign st_flat[2*i +: 2] = cell_st[i];
  end

  // response next-state
  wstate_e       cur_st;
  logic [DW-1:0] cur_data;
  logic          is_load, is_store, is_revoke;
  logic          rsp_valid_d, rsp_hit_d, regq_d, rvk_d;

  always_comb begin
    cur_st      = cell_st[cur_idx];
    cur_data    = cell_data[cur_idx];
    is_load     = req_valid && (op == OP_LOAD);
    is_store    = req_valid && (op == OP_STORE);
    is_revoke   = req_valid && (op == OP_REVOKE);
    rsp_valid_d = is_load | is_store;
    rsp_hit_d   = is_load ? (cur_st != WS_INV) : (cur_st == WS_REG);
    regq_d      = is_store && (cur_st != WS_REG);
    rvk_d       = is_revoke && (cur_st == WS_REG);
  end

  // response registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_state  <= 2'b00;
      regq_valid <= 1'b0;
      rvk_valid  <= 1'b0;
    end else begin
      rsp_valid  <= rsp_valid_d;
      rsp_hit    <= rsp_hit_d;
      rsp_state  <= cur_st;
      regq_valid <= regq_d;
      rvk_valid  <= rvk_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rsp_valid_d) rsp_data <= cur_data;
    if (rvk_d)       rvk_data <= cur_data;
    if (regq_d) begin
      regq_line <= req_line;
      regq_word <= req_word;
    end
  end

  cwt_llc_meta #(.LINES(LINES), .WORDS(WORDS)) u_meta (
    .clk        (clk),
    .rst_n      (rst_n),
    .fill_en    (req_valid && op == OP_FILL),
    .grant_en   (req_valid && op == OP_GRANT),
    .revoke_en  (rvk_d),
    .line       (req_line),
    .word       (req_word),
    .q_line     (meta_line),
    .q_valid    (meta_valid),
    .q_dirty    (meta_dirty),
    .q_owned    (meta_owned),
    .owned_flat (owned_flat)
  );
endmodule

// File: rtl/cwt_checker.sv
module cwt_checker #(
  parameter int NCELL = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic [2:0]         req_op,
  input logic               rsp_valid,
  input logic               regq_valid,
  input logic               rvk_valid,
  input logic [2*NCELL-1:0] st_flat,
  input logic [NCELL-1:0]   owned_flat
);
  logic [15:0] val_cnt;
  logic        own_mismatch;

  always_comb begin
    val_cnt      = '0;
    own_mismatch = 1'b0;
    for (int i = 0; i < NCELL; i++) begin
      if (st_flat[2*i +: 2] == 2'b01) val_cnt = val_cnt + 16'd1;
      if ((st_flat[2*i +: 2] == 2'b10) != owned_flat[i]) own_mismatch = 1'b1;
    end
  end

  p_load_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 3'd0) |=> rsp_valid);

  p_acq_drop_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 3'd2) |=> (val_cnt == 16'd0));

  p_regq_from_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
    regq_valid |-> $past(req_valid && req_op == 3'd1));

  p_owned_tracks_reg_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !own_mismatch);

  p_rvk_from_revoke_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rvk_valid |-> $past(req_valid && req_op == 3'd5));

  p_single_resp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rsp_valid, rvk_valid}));
endmodule

bind coh_word_tracker cwt_checker #(.NCELL(LINES*WORDS)) u_cwt_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_op     (req_op),
  .rsp_valid  (rsp_valid),
  .regq_valid (regq_valid),
  .rvk_valid  (rvk_valid),
  .st_flat    (st_flat),
  .owned_flat (owned_flat)
);

// File: tb/coh_word_tracker_bench.sv
module coh_word_tracker_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n;
  logic        req_valid, req_ro;
  logic [2:0]  req_op;
  logic [1:0]  req_line, req_word, meta_line;
  logic [31:0] req_wdata;
  logic        rsp_valid, rsp_hit, regq_valid, rvk_valid;
  logic        meta_valid, meta_dirty;
  logic [1:0]  rsp_state, regq_line, regq_word;
  logic [31:0] rsp_data, rvk_data;
  logic [3:0]  meta_owned;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  coh_word_tracker u_coh_word_tracker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_line(req_line), .req_word(req_word), .req_ro(req_ro),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_state(rsp_state), .rsp_data(rsp_data), .regq_valid(regq_valid),
    .regq_line(regq_line), .regq_word(regq_word), .rvk_valid(rvk_valid),
    .rvk_data(rvk_data), .meta_line(meta_line), .meta_valid(meta_valid),
    .meta_dirty(meta_dirty), .meta_owned(meta_owned)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed {
    logic [2:0]  op;
    logic [1:0]  ln;
    logic [1:0]  wrd;
    logic        ro;
    logic [31:0] wdat;
    logic        rv;
    logic        hit;
    logic [1:0]  st;
    logic        cd;
    logic [31:0] rd;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t TBL [NV] = '{
    '{3'd0, 2'd0, 2'd0, 1'b0, 32'h0,        1'b1, 1'b0, 2'b00, 1'b0, 32'h0,        4'd2}, // R2 miss on Invalid
    '{3'd3, 2'd0, 2'd0, 1'b0, 32'hA1A1A1A1, 1'b0, 1'b0, 2'b00, 1'b0, 32'h0,        4'd6}, // R6 fill Valid
    '{3'd0, 2'd0, 2'd0, 1'b0, 32'h0,        1'b1, 1'b1, 2'b01, 1'b1, 32'hA1A1A1A1, 4'd2}, // R2 hit Valid
    '{3'd3, 2'd0, 2'd1, 1'b1, 32'hB2B2B2B2, 1'b0, 1'b0, 2'b00, 1'b0, 32'h0,        4'd6}, // R6 fill ReadOnly
    '{3'd0, 2'd0, 2'd1, 1'b1, 32'h0,        1'b1, 1'b1, 2'b11, 1'b1, 32'hB2B2B2B2, 4'd6}, // R6 state 11
    '{3'd1, 2'd1, 2'd2, 1'b0, 32'hC3C3C3C3, 1'b1, 1'b0, 2'b00, 1'b0, 32'h0,        4'd4}, // R4 store miss
    '{3'd4, 2'd1, 2'd2, 1'b0, 32'h0,        1'b0, 1'b0, 2'b00, 1'b0, 32'h0,        4'd5}, // R5 grant
    '{3'd0, 2'd1, 2'd2, 1'b0, 32'h0,        1'b1, 1'b1, 2'b10, 1'b1, 32'hC3C3C3C3, 4'd5}, // R5 Registered hit
    '{3'd1, 2'd1, 2'd2, 1'b0, 32'hD4D4D4D4, 1'b1, 1'b1, 2'b10, 1'b0, 32'h0,        4'd4}, // R4 store hit
    '{3'd2, 2'd0, 2'd0, 1'b0, 32'h0,        1'b0, 1'b0, 2'b00, 1'b0, 32'h0,        4'd3}, // R3 acquire
    '{3'd0, 2'd0, 2'd0, 1'b0, 32'h0,        1'b1, 1'b0, 2'b00, 1'b0, 32'h0,        4'd3}, // R3 Valid dropped
    '{3'd0, 2'd0, 2'd1, 1'b1, 32'h0,        1'b1, 1'b1, 2'b11, 1'b1, 32'hB2B2B2B2, 4'd3}, // R3 ReadOnly kept
    '{3'd0, 2'd1, 2'd2, 1'b0, 32'h0,        1'b1, 1'b1, 2'b10, 1'b1, 32'hD4D4D4D4, 4'd3}, // R3 Registered kept
    '{3'd3, 2'd1, 2'd2, 1'b0, 32'hE5E5E5E5, 1'b0, 1'b0, 2'b00, 1'b0, 32'h0,        4'd6}, // R6 fill on owned
    '{3'd0, 2'd1, 2'd2, 1'b0, 32'h0,        1'b1, 1'b1, 2'b10, 1'b1, 32'hD4D4D4D4, 4'd6}  // R6 fill ignored
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // drive at a falling edge, return at the next falling edge with outputs settled
  task automatic issue(input logic [2:0] op, input logic [1:0] ln, input logic [1:0] wd,
                       input logic ro, input logic [31:0] dat);
    req_valid = 1'b1; req_op = op; req_line = ln; req_word = wd;
    req_ro = ro; req_wdata = dat;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=1 exp=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_op = 3'd0; req_line = 2'd0;
    req_word = 2'd0; req_ro = 1'b0; req_wdata = '0; meta_line = 2'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 rsp_valid", rsp_valid, 0);
    check("R1 regq_valid", regq_valid, 0);
    check("R1 rvk_valid", rvk_valid, 0);
    check("R1 meta", {meta_valid, meta_dirty, meta_owned}, 0);

    for (int i = 0; i < NV; i++) begin
      issue(TBL[i].op, TBL[i].ln, TBL[i].wrd, TBL[i].ro, TBL[i].wdat);
      check($sformatf("R%0d row %0d rsp_valid", TBL[i].rq, i), rsp_valid, TBL[i].rv);
      if (TBL[i].rv) begin
        check($sformatf("R%0d row %0d hit", TBL[i].rq, i), rsp_hit, TBL[i].hit);
        check($sformatf("R%0d row %0d state", TBL[i].rq, i), rsp_state, TBL[i].st);
      end
      if (TBL[i].cd)
        check($sformatf("R%0d row %0d data", TBL[i].rq, i), rsp_data, TBL[i].rd);
    end

    // R4 registration request on a store to an unowned word
    issue(3'd1, 2'd2, 2'd3, 1'b0, 32'h12345678);
    check("R4 regq_valid", regq_valid, 1);
    check("R4 regq addr", {regq_line, regq_word}, {2'd2, 2'd3});
    check("R4 miss", rsp_hit, 0);
    issue(3'd1, 2'd1, 2'd2, 1'b0, 32'hD4D4D4D4);
    check("R4 no regq when owned", regq_valid, 0);

    // R5 grant sets owned bit
    issue(3'd4, 2'd2, 2'd3, 1'b0, 32'h0);
    meta_line = 2'd2;
    #1;
    check("R5 owned line2", meta_owned, 4'b1000);
    issue(3'd0, 2'd2, 2'd3, 1'b0, 32'h0);
    check("R5 stored data kept", {rsp_hit, rsp_state, rsp_data}, {1'b1, 2'b10, 32'h12345678});

    // R8 line valid bits
    meta_line = 2'd0;
    #1;
    check("R8 filled line valid", meta_valid, 1);
    meta_line = 2'd3;
    #1;
    check("R8 unfilled line invalid", meta_valid, 0);

    // R7 revoke of an owned word
    issue(3'd5, 2'd1, 2'd2, 1'b0, 32'h0);
    check("R7 rvk_valid", rvk_valid, 1);
    check("R7 rvk_data", rvk_data, 32'hD4D4D4D4);
    meta_line = 2'd1;
    #1;
    check("R7 meta line1", {meta_dirty, meta_owned}, {1'b1, 4'b0000});
    issue(3'd0, 2'd1, 2'd2, 1'b0, 32'h0);
    check("R7 revoked word invalid", {rsp_hit, rsp_state}, {1'b0, 2'b00});

    // R7 revoke of an unowned word has no effect
    issue(3'd5, 2'd0, 2'd1, 1'b0, 32'h0);
    check("R7 no rvk when unowned", rvk_valid, 0);
    issue(3'd0, 2'd0, 2'd1, 1'b1, 32'h0);
    check("R7 ReadOnly untouched", {rsp_hit, rsp_state}, {1'b1, 2'b11});
    meta_line = 2'd0;
    #1;
    check("R7 clean line stays clean", meta_dirty, 0);

    // R1 reset in mid-run clears words and metadata
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    meta_line = 2'd2;
    #1;
    check("R1 meta after reset", {meta_valid, meta_dirty, meta_owned}, 0);
    issue(3'd0, 2'd0, 2'd1, 1'b0, 32'h0);
    check("R1 word invalid after reset", {rsp_hit, rsp_state}, {1'b0, 2'b00});

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule